// File: doc/BRIEF.md
# Dual-Clock FIFO with Loadable Threshold Flags

This block is a single 12-bit first-in first-out channel whose write side and read side each run on their own clock. Words arrive on the write clock when the write enable is high, and they leave on the read clock into a registered output. A low-active output enable either drives that register onto the output or forces the output to zero. The write and read clocks may be the same net or two unrelated clocks. Pointers cross between the domains as gray codes through two-flop synchronizers. This keeps each flag safe in the domain that uses it.

Two threshold registers control the almost-empty and almost-full flags. They have no configuration port of their own. Software writes them through the data input while the low-active load strobe is held. A one-bit select picks which register takes the word. Each side has its own active-low reset. Pulling both low together restarts the channel with no stored words and default thresholds, for example after the surrounding system changes its operating mode.

Top module: `dual_clock_thresh_fifo`

## Requirements
- R1: After reset, empty and almost_empty are 1, full and almost_full are 0, and the output register holds zero.
- R2: Words read out match the written 12-bit words in order, for any bit pattern.
- R3: On a write-clock edge with ld_n low, din loads a threshold register and no word enters the FIFO, even if wr_en is high. thr_sel 0 selects almost-empty and 1 selects almost-full. din bit 0 is the threshold LSB.
- R4: full is 1 when DEPTH words are stored. A write while full is dropped, and the dropped word never reaches the output.
- R5: A read while empty is ignored. The output register keeps its value and the read pointer does not move, so the next written word is the next word read.
- R6: almost_full is 1 exactly when the free space seen in the write domain is at or below the almost-full threshold.
- R7: almost_empty is 1 exactly when the stored count seen in the read domain is at or below the almost-empty threshold.
- R8: With oe_n high, dout is zero. With oe_n low, dout shows the registered read word.
- R9: Driving wr_rst_n and rd_rst_n low together empties the FIFO and restores both thresholds to their default of 8.
- R10: Data and flags are correct when rd_clk is unrelated to wr_clk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| wr_rst_n | input | 1 | Active-low reset of the write side |
| wr_en | input | 1 | Write request |
| ld_n | input | 1 | Active-low threshold load strobe |
| thr_sel | input | 1 | Threshold select: 0 almost-empty, 1 almost-full |
| din | input | 12 | Write data or threshold value |
| rd_clk | input | 1 | Read clock |
| rd_rst_n | input | 1 | Active-low reset of the read side |
| rd_en | input | 1 | Read request |
| oe_n | input | 1 | Active-low output enable |
| dout | output | 12 | Registered read data, zero when disabled |
| full | output | 1 | FIFO holds DEPTH words |
| empty | output | 1 | FIFO holds no words |
| almost_full | output | 1 | Free space at or below almost-full threshold |
| almost_empty | output | 1 | Stored count at or below almost-empty threshold |

## Verification
The bench builds the block with DEPTH 16 and a 12-bit width, keeping the default threshold of 8. With these values both flags flip within a handful of writes. Filling to full and overflowing takes only sixteen words. Reading the result back stays short enough to repeat with a shared clock and again with an unrelated 7 ns read clock.

// File: rtl/dual_clock_thresh_fifo.sv
module dual_clock_thresh_fifo #(
  parameter int DW      = 12,
  parameter int DEPTH   = 256,
  parameter int THR_RST = 8
) (
  input  logic          wr_clk,
  input  logic          wr_rst_n,
  input  logic          wr_en,
  input  logic          ld_n,
  input  logic          thr_sel,
  input  logic [DW-1:0] din,
  input  logic          rd_clk,
  input  logic          rd_rst_n,
  input  logic          rd_en,
  input  logic          oe_n,
  output logic [DW-1:0] dout,
  output logic          full,
  output logic          empty,
  output logic          almost_full,
  output logic          almost_empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wbin, wgray, rgray_s1, rgray_s2;
  logic [PW-1:0] rbin, rgray, wgray_s1, wgray_s2;
  logic [DW-1:0] thr_ae, thr_af, dout_q;
  logic [PW-1:0] wcount, rcount;
  logic          do_wr, do_rd;

  // write domain
  assign wcount      = wbin - g2b(rgray_s2);
  assign full        = (wcount == PW'(DEPTH));
  assign almost_full = DW'(PW'(DEPTH) - wcount) <= thr_af;
  assign do_wr       = ld_n && wr_en && !full;

  always_ff @(posedge wr_clk)
    if (do_wr) mem[wbin[AW-1:0]] <= din;

  always_ff @(posedge wr_clk or negedge wr_rst_n)
    if (!wr_rst_n) begin
      wbin     <= '0;
      wgray    <= '0;
      rgray_s1 <= '0;
      rgray_s2 <= '0;
      thr_ae   <= DW'(THR_RST);
      thr_af   <= DW'(THR_RST);
    end else begin
      rgray_s1 <= rgray;
      rgray_s2 <= rgray_s1;
      if (do_wr) begin
        wbin  <= wbin + 1'b1;
        wgray <= (wbin + 1'b1) ^ ((wbin + 1'b1) >> 1);
      end
      if (!ld_n) begin
        if (thr_sel) thr_af <= din;
        else         thr_ae <= din;
      end
    end

  // read domain
  assign rcount       = g2b(wgray_s2) - rbin;
  assign empty        = (rcount == '0);
  assign almost_empty = DW'(rcount) <= thr_ae;
  assign do_rd        = rd_en && !empty;
  assign dout         = oe_n ? '0 : dout_q;

  always_ff @(posedge rd_clk or negedge rd_rst_n)
    if (!rd_rst_n) begin
      rbin     <= '0;
      rgray    <= '0;
      wgray_s1 <= '0;
      wgray_s2 <= '0;
      dout_q   <= '0;
    end else begin
      wgray_s1 <= wgray;
      wgray_s2 <= wgray_s1;
      if (do_rd) begin
        dout_q <= mem[rbin[AW-1:0]];
        rbin   <= rbin + 1'b1;
        rgray  <= (rbin + 1'b1) ^ ((rbin + 1'b1) >> 1);
      end
    end

  AST_NO_WR_WHEN_FULL: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (full && wr_en && ld_n) |=> $stable(wbin)); // R4
  AST_COUNT_BOUND: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wcount <= PW'(DEPTH)); // R4
  AST_LOAD_NO_WRITE: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    !ld_n |=> $stable(wbin)); // R3
  AST_NO_RD_WHEN_EMPTY: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (empty && rd_en) |=> ($stable(rbin) && $stable(dout_q))); // R5
  AST_FULL_IMPLIES_AF: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    full |-> almost_full); // R6
  AST_EMPTY_IMPLIES_AE: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    empty |-> almost_empty); // R7
endmodule

// File: tb/tb_dual_clock_thresh_fifo.sv
`timescale 1ns/1ps
module tb_dual_clock_thresh_fifo;
  localparam int DW = 12;
  localparam int DEPTH = 16;

  logic clk = 0, alt_clk = 0, use_alt = 0;
  logic wr_rst_n = 0, rd_rst_n = 0, wr_en = 0, ld_n = 1, thr_sel = 0;
  logic rd_en = 0, oe_n = 0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic full, empty, almost_full, almost_empty;
  logic rd_clk;
  int checks = 0, errors = 0, cyc = 0;
  logic [DW-1:0] v;

  always #2.5 clk = ~clk;
  always #3.5 alt_clk = ~alt_clk;
  assign rd_clk = use_alt ? alt_clk : clk;

  dual_clock_thresh_fifo #(.DW(DW), .DEPTH(DEPTH), .THR_RST(8)) dut (
    .wr_clk(clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .ld_n(ld_n), .thr_sel(thr_sel),
    .din(din), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .oe_n(oe_n),
    .dout(dout), .full(full), .empty(empty), .almost_full(almost_full),
    .almost_empty(almost_empty));

  // {data, almost_empty expected, almost_full expected} after writing entry i (count i+1)
  localparam logic [13:0] VEC [10] = '{
    {12'h001, 1'b1, 1'b0}, {12'hFFF, 1'b1, 1'b0}, {12'h5A5, 1'b1, 1'b0},
    {12'hA5A, 1'b1, 1'b0}, {12'h800, 1'b1, 1'b0}, {12'h7FF, 1'b1, 1'b0},
    {12'h123, 1'b1, 1'b0}, {12'hC3C, 1'b1, 1'b1}, {12'h0F0, 1'b0, 1'b1},
    {12'h3E9, 1'b0, 1'b1}};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reset_both();
    @(negedge clk);
    wr_rst_n = 0; rd_rst_n = 0;
    waitw(3);
    wr_rst_n = 1; rd_rst_n = 1;
    waitw(2);
  endtask

  task automatic wr_word(input logic [DW-1:0] d);
    @(negedge clk); din = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic ld_thr(input logic sel, input logic [DW-1:0] d);
    @(negedge clk); din = d; thr_sel = sel; ld_n = 0; wr_en = 1;
    @(negedge clk); ld_n = 1; wr_en = 0;
  endtask

  task automatic rd_word(output logic [DW-1:0] q);
    @(negedge rd_clk); rd_en = 1;
    @(negedge rd_clk); rd_en = 0; q = dout;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  initial begin
    reset_both();
    check("R1 empty", empty, 1);
    check("R1 almost_empty", almost_empty, 1);
    check("R1 full", full, 0);
    check("R1 almost_full", almost_full, 0);
    check("R1 dout", dout, 0);

    for (int i = 0; i < 10; i++) begin
      wr_word(VEC[i][13:2]);
      waitw(6);
      check("R7 almost_empty vector", almost_empty, VEC[i][1]);
      check("R6 almost_full vector", almost_full, VEC[i][0]);
    end
    for (int i = 0; i < 10; i++) begin
      rd_word(v);
      check("R2 read order", v, VEC[i][13:2]);
    end
    waitw(6);
    check("R7 empty after drain", empty, 1);

    rd_word(v); rd_word(v);
    check("R5 dout held on empty read", v, 12'h3E9);
    wr_word(12'hABC); waitw(6);
    rd_word(v);
    check("R5 next word after empty read", v, 12'hABC);

    @(negedge clk); oe_n = 1; #1;
    check("R8 output disabled", dout, 0);
    oe_n = 0; #1;
    check("R8 output enabled", dout, 12'hABC);

    ld_thr(1'b0, 12'd2);
    ld_thr(1'b1, 12'd3);
    waitw(6);
    check("R3 load leaves FIFO empty", empty, 1);
    for (int k = 0; k < 3; k++) wr_word(12'h100 + 12'(k));
    waitw(6);
    check("R3 R7 almost_empty with threshold 2", almost_empty, 0);
    for (int k = 3; k < 12; k++) wr_word(12'h100 + 12'(k));
    waitw(6);
    check("R6 almost_full off at free 4", almost_full, 0);
    wr_word(12'h10C); waitw(6);
    check("R6 almost_full on at free 3", almost_full, 1);
    for (int k = 13; k < 16; k++) wr_word(12'h100 + 12'(k));
    waitw(6);
    check("R4 full", full, 1);
    wr_word(12'hEEE); waitw(6);
    check("R4 full after dropped write", full, 1);
    for (int k = 0; k < 16; k++) begin
      rd_word(v);
      check("R4 data after full", v, 12'h100 + 12'(k));
    end
    waitw(6);
    check("R4 empty after 16 reads", empty, 1);
    rd_word(v);
    check("R4 dropped word absent", v, 12'h10F);

    wr_word(12'h055); wr_word(12'h066);
    reset_both();
    check("R9 empty after joint reset", empty, 1);
    check("R9 full after joint reset", full, 0);
    for (int k = 0; k < 5; k++) wr_word(12'h300 + 12'(k));
    waitw(6);
    check("R9 almost_empty threshold back to 8", almost_empty, 1);
    rd_word(v);
    check("R9 first word after restart", v, 12'h300);

    @(negedge clk); wr_rst_n = 0; rd_rst_n = 0; use_alt = 1;
    waitw(4);
    wr_rst_n = 1; rd_rst_n = 1;
    waitw(4);
    check("R10 empty on unrelated clock", empty, 1);
    for (int k = 0; k < 6; k++) wr_word(12'h200 + 12'(k * 7));
    waitw(10);
    check("R10 not empty", empty, 0);
    for (int k = 0; k < 6; k++) begin
      rd_word(v);
      check("R10 data", v, 12'h200 + 12'(k * 7));
    end
    waitw(10);
    check("R10 empty after drain", empty, 1);

    finish_run();
  end
endmodule